// File: doc/BRIEF.md
# Two-Level Page Translation Unit

This block turns 32-bit linear addresses into physical addresses through a directory table followed by a page table, both held in memory. Pages are 4 KB. A fully associative cache of recently used translations lets a repeated access to a page finish without touching memory. On a miss the unit fetches the directory entry and then the page table entry, one 32-bit word at a time. It also writes back the accessed and dirty status bits when they need to change.

A translation request carries a linear address, a write flag and a user flag. It enters through a valid/ready handshake. `req_ready` is high only while the unit is idle, so the requester must hold `req_valid` and the request fields steady until it sees `req_ready`. The unit handles one request at a time. The answer is a physical address or a fault, and it is held on `rsp_*` with `rsp_valid` until `rsp_ready` is seen at a clock edge. Memory requests use the same rule. `mem_valid`, `mem_we`, `mem_addr` and `mem_wdata` stay unchanged until `mem_ready`. Each read returns exactly one `mem_rvalid` pulse some cycles later, and writes return nothing.

The directory base register is written through `base_we`. Writing it, or pulsing `flush`, empties the translation cache. A faulting request leaves its linear address in `fault_addr`.

Top module: `pgxlate_unit`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `mem_valid` are 0, and `base_q` and `fault_addr` read 0.
- R2: On a cache miss the unit reads the directory entry at `{base_q[31:12], lin[31:22], 2'b00}` and then the table entry at `{dir[31:12], lin[21:12], 2'b00}`. A permitted access returns `{tab[31:12], lin[11:0]}` with `rsp_fault` = 0.
- R3: `base_q` returns the written value with bits 11:0 forced to zero.
- R4: A later access to a cached page, with no dirty-bit update needed, returns the correct physical address and makes no memory request.
- R5: If the present bit (bit 0) is clear in either entry, the request completes with `rsp_fault` = 1 and `rsp_phys` = 0, and `fault_addr` takes the linear address. No cache entry is made, so a repeat request walks again.
- R6: A user access faults when the user bit (bit 2) is clear in either entry. A supervisor access to the same page succeeds. A cached translation keeps this check.
- R7: A user write faults when the write bit (bit 1) is clear in either entry. A user read of such a page succeeds, and so does a supervisor write.
- R8: After a successful walk, a directory entry whose accessed bit (bit 5) was clear is written back with bit 5 set. A table entry is written back with bit 5 set, and with bit 6 set on a write. This happens before the response, and only when some bit actually changes.
- R9: Bit 6 of a directory entry is never set by the unit and is not needed for a write.
- R10: A write that hits a cached page whose table entry is not yet dirty walks again, writes the dirty bit and refreshes that cache entry. Later writes to the page hit with no memory traffic.
- R11: The cache holds 32 pages with round-robin replacement, starting at slot 0 after reset or invalidation. Filling a 33rd distinct page evicts the first one filled.
- R12: A pulse on `flush` or a write to the base register invalidates every cached translation.
- R13: `req_ready` is 0 from acceptance until the response is taken. While `rsp_valid` is 1 and `rsp_ready` is 0, the response fields hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Unit idle, request accepted at this edge |
| req_lin | input | 32 | Linear address |
| req_wr | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user level |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_phys | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Translation faulted |
| base_we | input | 1 | Write the directory base register |
| base_wdata | input | 32 | New directory base |
| base_q | output | 32 | Directory base, low 12 bits zero |
| flush | input | 1 | Invalidate the translation cache |
| fault_addr | output | 32 | Linear address of the latest fault |
| mem_valid | output | 1 | Memory word request valid |
| mem_ready | input | 1 | Memory accepts the request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word address in bytes |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Read data |

## Verification
The embedded properties assume that the memory returns exactly one `mem_rvalid` per accepted read and never one for a write. They also assume that `rsp_ready` may be withheld for any number of cycles, and that `base_we` and `flush` arrive only while no request is in flight. The bench keeps to these rules. Its memory model answers each read one cycle after acceptance, and it stalls `mem_ready` on every third cycle. Base writes and flushes are issued only between completed requests. Response back-pressure is applied only in the scenario that checks the hold rule.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
  localparam int LIN_W     = 32;
  localparam int OFF_W     = 12;
  localparam int IDX_W     = 10;
  localparam int VPN_W     = LIN_W - OFF_W;
  localparam int ENT_PRES  = 0;
  localparam int ENT_WRT   = 1;
  localparam int ENT_USR   = 2;
  localparam int ENT_ACC   = 5;
  localparam int ENT_DRTY  = 6;
  localparam logic [31:0] ACC_MASK  = 32'h1 << ENT_ACC;
  localparam logic [31:0] DRTY_MASK = 32'h1 << ENT_DRTY;

  typedef struct packed {
    logic [VPN_W-1:0] ppn;
    logic             usr_ok;
    logic             wr_ok;
    logic             dirty;
  } xl_ent_t;

  typedef enum logic [3:0] {
    W_IDLE, W_LOOK, W_DIR_RQ, W_DIR_WT, W_TAB_RQ, W_TAB_WT,
    W_DIR_WR, W_TAB_WR, W_FILL, W_RESP
  } wstate_e;

  function automatic logic tab_needs_wb(input logic [31:0] tab, input logic wr);
    return !tab[ENT_ACC] || (wr && !tab[ENT_DRTY]);
  endfunction
endpackage

// File: rtl/pgx_perm.sv
module pgx_perm
  import pgx_pkg::*;
(
  input  logic [2:0] dir_lo,
  input  logic [2:0] tab_lo,
  input  logic       usr,
  input  logic       wr,
  output logic       u_ok,
  output logic       w_ok,
  output logic       deny
);
  logic present;
  always_comb begin
    present = dir_lo[ENT_PRES] & tab_lo[ENT_PRES];
    u_ok    = dir_lo[ENT_USR] & tab_lo[ENT_USR];
    w_ok    = dir_lo[ENT_WRT] & tab_lo[ENT_WRT];
    deny    = !present || (usr && (!u_ok || (wr && !w_ok)));
  end
endmodule

// File: rtl/pgx_tlb.sv
module pgx_tlb
  import pgx_pkg::*;
#(
  parameter int ENTRIES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inval,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output xl_ent_t          lk_ent,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  xl_ent_t          fill_ent
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld_q, lk_match, fl_match;
  logic [VPN_W-1:0]   tag_q [ENTRIES];
  xl_ent_t            dat_q [ENTRIES];
  logic [IW-1:0]      rr_q, lk_idx, fl_idx, wr_idx;
  logic               fl_hit;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lk_match[g] = vld_q[g] && (tag_q[g] == lk_vpn);
    assign fl_match[g] = vld_q[g] && (tag_q[g] == fill_vpn);
  end

  always_comb begin
    lk_idx = '0;
    fl_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) lk_idx = IW'(i);
      if (fl_match[i]) fl_idx = IW'(i);
    end
    lk_hit = |lk_match;
    lk_ent = dat_q[lk_idx];
    fl_hit = |fl_match;
    wr_idx = fl_hit ? fl_idx : rr_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      rr_q  <= '0;
    end else if (inval) begin
      vld_q <= '0;
      rr_q  <= '0;
    end else if (fill_en) begin
      vld_q[wr_idx] <= 1'b1;
      if (!fl_hit) rr_q <= (rr_q == IW'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en && !inval) begin
      tag_q[wr_idx] <= fill_vpn;
      dat_q[wr_idx] <= fill_ent;
    end
  end

  // R11
  tlb_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));
endmodule

// File: rtl/pgx_walker.sv
module pgx_walker
  import pgx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [LIN_W-1:0] req_lin,
  input  logic             req_wr,
  input  logic             req_user,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [LIN_W-1:0] rsp_phys,
  output logic             rsp_fault,
  input  logic [VPN_W-1:0] base_hi,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic             mem_rvalid,
  input  logic [31:0]      mem_rdata,
  output logic [VPN_W-1:0] lk_vpn,
  input  logic             lk_hit,
  input  xl_ent_t          lk_ent,
  output logic             fill_en,
  output xl_ent_t          fill_ent,
  output logic             raise_fault,
  output logic [LIN_W-1:0] cur_lin
);
  wstate_e          st;
  logic [LIN_W-1:0] lin_q, phys_q;
  logic             wr_q, usr_q, fault_q;
  logic [31:0]      dir_q, tab_q;
  logic [31:0]      dir_addr, tab_addr;
  logic             hit_deny, walk_deny;
  logic             unused_hu, unused_hw, unused_wu, unused_ww, unused_bits;

  pgx_perm u_hperm (
    .dir_lo ({lk_ent.usr_ok, lk_ent.wr_ok, 1'b1}),
    .tab_lo ({lk_ent.usr_ok, lk_ent.wr_ok, 1'b1}),
    .usr    (usr_q), .wr (wr_q),
    .u_ok   (unused_hu), .w_ok (unused_hw), .deny (hit_deny)
  );

  pgx_perm u_wperm (
    .dir_lo (dir_q[2:0]), .tab_lo (mem_rdata[2:0]),
    .usr    (usr_q), .wr (wr_q),
    .u_ok   (unused_wu), .w_ok (unused_ww), .deny (walk_deny)
  );

  assign unused_bits = ^{dir_q[11:7], dir_q[ENT_DRTY], dir_q[4:3],
                         tab_q[11:7], tab_q[4:3], mem_rdata[11:7], mem_rdata[4:3]};

  always_comb begin
    dir_addr  = {base_hi, lin_q[31:22], 2'b00};
    tab_addr  = {dir_q[31:12], lin_q[21:12], 2'b00};
    req_ready = (st == W_IDLE);
    rsp_valid = (st == W_RESP);
    rsp_phys  = phys_q;
    rsp_fault = fault_q;
    mem_valid = (st == W_DIR_RQ) || (st == W_TAB_RQ) || (st == W_DIR_WR) || (st == W_TAB_WR);
    mem_we    = (st == W_DIR_WR) || (st == W_TAB_WR);
    mem_addr  = ((st == W_DIR_RQ) || (st == W_DIR_WR)) ? dir_addr : tab_addr;
    mem_wdata = (st == W_DIR_WR) ? (dir_q | ACC_MASK)
                                 : (tab_q | ACC_MASK | (wr_q ? DRTY_MASK : 32'h0));
    lk_vpn    = lin_q[31:12];
    fill_en   = (st == W_FILL);
    fill_ent.ppn    = tab_q[31:12];
    fill_ent.usr_ok = dir_q[ENT_USR] & tab_q[ENT_USR];
    fill_ent.wr_ok  = dir_q[ENT_WRT] & tab_q[ENT_WRT];
    fill_ent.dirty  = tab_q[ENT_DRTY] | wr_q;
    cur_lin   = lin_q;
    raise_fault = ((st == W_LOOK) && lk_hit && hit_deny) ||
                  ((st == W_DIR_WT) && mem_rvalid && !mem_rdata[ENT_PRES]) ||
                  ((st == W_TAB_WT) && mem_rvalid && walk_deny);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= W_IDLE;
      lin_q   <= '0;
      phys_q  <= '0;
      wr_q    <= 1'b0;
      usr_q   <= 1'b0;
      fault_q <= 1'b0;
      dir_q   <= '0;
      tab_q   <= '0;
    end else begin
      unique case (st)
        W_IDLE: if (req_valid) begin
          lin_q   <= req_lin;
          wr_q    <= req_wr;
          usr_q   <= req_user;
          fault_q <= 1'b0;
          st      <= W_LOOK;
        end
        W_LOOK: begin
          if (lk_hit && hit_deny) begin
            fault_q <= 1'b1;
            phys_q  <= '0;
            st      <= W_RESP;
          end else if (lk_hit && !(wr_q && !lk_ent.dirty)) begin
            phys_q <= {lk_ent.ppn, lin_q[OFF_W-1:0]};
            st     <= W_RESP;
          end else begin
            st <= W_DIR_RQ;
          end
        end
        W_DIR_RQ: if (mem_ready) st <= W_DIR_WT;
        W_DIR_WT: if (mem_rvalid) begin
          dir_q <= mem_rdata;
          if (!mem_rdata[ENT_PRES]) begin
            fault_q <= 1'b1;
            phys_q  <= '0;
            st      <= W_RESP;
          end else begin
            st <= W_TAB_RQ;
          end
        end
        W_TAB_RQ: if (mem_ready) st <= W_TAB_WT;
        W_TAB_WT: if (mem_rvalid) begin
          tab_q <= mem_rdata;
          if (walk_deny) begin
            fault_q <= 1'b1;
            phys_q  <= '0;
            st      <= W_RESP;
          end else if (!dir_q[ENT_ACC]) begin
            st <= W_DIR_WR;
          end else if (tab_needs_wb(mem_rdata, wr_q)) begin
            st <= W_TAB_WR;
          end else begin
            st <= W_FILL;
          end
        end
        W_DIR_WR: if (mem_ready) st <= tab_needs_wb(tab_q, wr_q) ? W_TAB_WR : W_FILL;
        W_TAB_WR: if (mem_ready) st <= W_FILL;
        W_FILL: begin
          phys_q <= {tab_q[31:12], lin_q[OFF_W-1:0]};
          st     <= W_RESP;
        end
        W_RESP: if (rsp_ready) st <= W_IDLE;
        default: st <= W_IDLE;
      endcase
    end
  end

  // R13
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_phys) && $stable(rsp_fault));
  // R13
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  // R4
  hit_no_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == W_LOOK) && lk_hit && !hit_deny && !(wr_q && !lk_ent.dirty) |=> rsp_valid && !mem_valid);
  // R8
  dirty_before_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we && (mem_addr == tab_addr) && (st == W_TAB_WR) && wr_q |-> mem_wdata[ENT_DRTY]);
  // R5
  fill_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> rsp_valid && !rsp_fault);
  // R9
  dir_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we && (st == W_DIR_WR) |-> mem_wdata[ENT_DRTY] == dir_q[ENT_DRTY]);
endmodule

// File: rtl/pgxlate_unit.sv
module pgxlate_unit
  import pgx_pkg::*;
#(
  parameter int ENTRIES = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_lin,
  input  logic        req_wr,
  input  logic        req_user,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_phys,
  output logic        rsp_fault,
  input  logic        base_we,
  input  logic [31:0] base_wdata,
  output logic [31:0] base_q,
  input  logic        flush,
  output logic [31:0] fault_addr,
  output logic        mem_valid,
  input  logic        mem_ready,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata
);
  logic [VPN_W-1:0] base_hi, lk_vpn;
  logic             lk_hit, fill_en, raise_fault;
  xl_ent_t          lk_ent, fill_ent;
  logic [31:0]      cur_lin;
  logic             unused_low;

  assign unused_low = ^base_wdata[OFF_W-1:0];
  assign base_q     = {base_hi, {OFF_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_hi    <= '0;
      fault_addr <= '0;
    end else begin
      if (base_we) base_hi <= base_wdata[31:OFF_W];
      if (raise_fault) fault_addr <= cur_lin;
    end
  end

  pgx_tlb #(.ENTRIES(ENTRIES)) u_tlb (
    .clk (clk), .rst_n (rst_n), .inval (flush | base_we),
    .lk_vpn (lk_vpn), .lk_hit (lk_hit), .lk_ent (lk_ent),
    .fill_en (fill_en), .fill_vpn (lk_vpn), .fill_ent (fill_ent)
  );

  pgx_walker u_walk (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready), .req_lin (req_lin),
    .req_wr (req_wr), .req_user (req_user),
    .rsp_valid (rsp_valid), .rsp_ready (rsp_ready), .rsp_phys (rsp_phys),
    .rsp_fault (rsp_fault), .base_hi (base_hi),
    .mem_valid (mem_valid), .mem_ready (mem_ready), .mem_we (mem_we),
    .mem_addr (mem_addr), .mem_wdata (mem_wdata),
    .mem_rvalid (mem_rvalid), .mem_rdata (mem_rdata),
    .lk_vpn (lk_vpn), .lk_hit (lk_hit), .lk_ent (lk_ent),
    .fill_en (fill_en), .fill_ent (fill_ent),
    .raise_fault (raise_fault), .cur_lin (cur_lin)
  );

  // R5
  fault_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    raise_fault |=> fault_addr == $past(cur_lin));
  // R13
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
endmodule

// File: tb/pgxlate_unit_test.sv
module pgxlate_unit_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_wr = 0, req_user = 0, rsp_ready = 0;
  logic base_we = 0, flush = 0, mem_ready = 0, mem_rvalid = 0;
  logic [31:0] req_lin = 0, base_wdata = 0, mem_rdata = 0;
  logic req_ready, rsp_valid, rsp_fault, mem_valid, mem_we;
  logic [31:0] rsp_phys, base_q, fault_addr, mem_addr, mem_wdata;

  logic [31:0] pmem [logic [31:0]];
  logic [31:0] rd_log [256];
  int nrd = 0, nwr = 0, cyc = 0, nchk = 0, nfail = 0;

  localparam logic [31:0] BASE = 32'h0002_0000;
  localparam logic [7:0] FP = 8'h01, FW = 8'h02, FU = 8'h04, FA = 8'h20, FD = 8'h40;

  pgxlate_unit uut (.*);

  always #4 clk = ~clk;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return pmem.exists(a) ? pmem[a] : 32'h0;
  endfunction

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_valid && mem_ready) begin
      if (mem_we) begin
        pmem[mem_addr] = mem_wdata;
        nwr++;
      end else begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= rd(mem_addr);
        rd_log[nrd % 256] = mem_addr;
        nrd++;
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    mem_ready <= (cyc % 3) != 2;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] dir_at(input logic [31:0] lin);
    return BASE + {20'h0, lin[31:22], 2'b00};
  endfunction
  function automatic logic [31:0] tbl_of(input logic [31:0] lin);
    return 32'h0010_0000 + {10'h0, lin[31:22], 12'h0};
  endfunction
  function automatic logic [31:0] tab_at(input logic [31:0] lin);
    return tbl_of(lin) + {20'h0, lin[21:12], 2'b00};
  endfunction

  task automatic map_page(input logic [31:0] lin, input logic [7:0] df, input logic [7:0] tf,
                          input logic [19:0] ppn);
    pmem[dir_at(lin)] = tbl_of(lin) | {24'h0, df};
    pmem[tab_at(lin)] = {ppn, 12'h0} | {24'h0, tf};
  endtask

  task automatic xlate(input logic [31:0] lin, input logic wr, input logic usr, input int hold,
                       output logic [31:0] ph, output logic flt, output int reads, output int writes);
    int r0 = nrd, w0 = nwr;
    logic [31:0] ph0;
    logic f0;
    @(negedge clk);
    req_lin = lin; req_wr = wr; req_user = usr; req_valid = 1'b1;
    while (1) begin
      if (req_ready) begin
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    ph0 = rsp_phys; f0 = rsp_fault;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      chk("R13 phys held", rsp_phys, ph0);
      chk("R13 fault held", {31'h0, rsp_fault}, {31'h0, f0});
      chk("R13 req_ready low", {31'h0, req_ready}, 32'h0);
    end
    ph = rsp_phys; flt = rsp_fault;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    reads = nrd - r0; writes = nwr - w0;
  endtask

  task automatic set_base(input logic [31:0] v);
    @(negedge clk); base_we = 1'b1; base_wdata = v;
    @(negedge clk); base_we = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  logic [31:0] ph;
  logic flt;
  int rs, ws;

  task automatic t_reset();
    chk("R1 req_ready", {31'h0, req_ready}, 32'h1);
    chk("R1 rsp_valid", {31'h0, rsp_valid}, 32'h0);
    chk("R1 mem_valid", {31'h0, mem_valid}, 32'h0);
    chk("R1 base_q", base_q, 32'h0);
    chk("R1 fault_addr", fault_addr, 32'h0);
    set_base(BASE | 32'hABC);
    chk("R3 base low bits", base_q, BASE);
  endtask

  task automatic t_walk();
    logic [31:0] a = 32'h0040_3123;
    map_page(a, FP|FW|FU, FP|FW|FU, 20'hABCDE);
    xlate(a, 0, 0, 0, ph, flt, rs, ws);
    chk("R2 phys", ph, 32'hABCDE123);
    chk("R2 fault", {31'h0, flt}, 32'h0);
    chk("R2 reads", rs, 2);
    chk("R2 dir addr", rd_log[(nrd - 2) % 256], 32'h0002_0004);
    chk("R2 tab addr", rd_log[(nrd - 1) % 256], 32'h0010_100C);
    chk("R8 writes", ws, 2);
    chk("R8 dir acc", rd(dir_at(a)) & 32'h60, 32'h20);
    chk("R8 tab acc no dirty", rd(tab_at(a)) & 32'h60, 32'h20);
    xlate(32'h0040_3222, 0, 0, 0, ph, flt, rs, ws);
    chk("R4 phys", ph, 32'hABCDE222);
    chk("R4 no reads", rs + ws, 0);
  endtask

  task automatic t_dirty();
    xlate(32'h0040_3010, 1, 0, 0, ph, flt, rs, ws);
    chk("R10 phys", ph, 32'hABCDE010);
    chk("R10 rewalk", rs, 2);
    chk("R10 tab dirty", rd(tab_at(32'h0040_3000)) & 32'h60, 32'h60);
    xlate(32'h0040_3020, 1, 0, 0, ph, flt, rs, ws);
    chk("R10 later write hits", rs + ws, 0);
    chk("R10 later phys", ph, 32'hABCDE020);
  endtask

  task automatic t_dir_dirty();
    logic [31:0] b = 32'h0080_5004, c = 32'h00C0_7008;
    map_page(b, FP|FW|FU|FA, FP|FW|FU|FA, 20'h11111);
    xlate(b, 1, 0, 0, ph, flt, rs, ws);
    chk("R9 one write", ws, 1);
    chk("R9 dir bit6 clear", rd(dir_at(b)) & 32'h40, 32'h0);
    chk("R8 tab dirty set", rd(tab_at(b)) & 32'h60, 32'h60);
    map_page(c, FP|FW|FU|FA, FP|FW|FU|FA|FD, 20'h22222);
    xlate(c, 1, 0, 0, ph, flt, rs, ws);
    chk("R9 no write needed", ws, 0);
    chk("R9 phys", ph, 32'h22222008);
    chk("R9 no fault", {31'h0, flt}, 32'h0);
  endtask

  task automatic t_absent();
    logic [31:0] d = 32'h0100_9ABC, e = 32'h0140_0010;
    xlate(d, 0, 0, 0, ph, flt, rs, ws);
    chk("R5 dir absent fault", {31'h0, flt}, 32'h1);
    chk("R5 phys zero", ph, 32'h0);
    chk("R5 fault_addr", fault_addr, d);
    chk("R5 one read", rs, 1);
    xlate(d, 0, 0, 0, ph, flt, rs, ws);
    chk("R5 no fill rewalk", rs, 1);
    map_page(e, FP|FW|FU, FW|FU, 20'h33333);
    xlate(e, 0, 0, 0, ph, flt, rs, ws);
    chk("R5 tab absent fault", {31'h0, flt}, 32'h1);
    chk("R5 fault_addr tab", fault_addr, e);
    chk("R5 no writes", ws, 0);
  endtask

  task automatic t_user();
    logic [31:0] f = 32'h0180_1040, g = 32'h01C0_2050;
    map_page(f, FP|FW|FU, FP|FW, 20'h44444);
    xlate(f, 0, 1, 0, ph, flt, rs, ws);
    chk("R6 user to sup tab", {31'h0, flt}, 32'h1);
    xlate(f, 0, 0, 0, ph, flt, rs, ws);
    chk("R6 sup ok", {31'h0, flt}, 32'h0);
    chk("R6 sup phys", ph, 32'h44444040);
    xlate(f, 0, 1, 0, ph, flt, rs, ws);
    chk("R6 cached user fault", {31'h0, flt}, 32'h1);
    chk("R6 cached no reads", rs, 0);
    map_page(g, FP|FW, FP|FW|FU, 20'h55555);
    xlate(g, 0, 1, 0, ph, flt, rs, ws);
    chk("R6 user to sup dir", {31'h0, flt}, 32'h1);
    chk("R6 fault_addr", fault_addr, g);
  endtask

  task automatic t_rw();
    logic [31:0] h = 32'h0200_3060;
    map_page(h, FP|FW|FU, FP|FU, 20'h66666);
    xlate(h, 1, 1, 0, ph, flt, rs, ws);
    chk("R7 user write ro", {31'h0, flt}, 32'h1);
    xlate(h, 0, 1, 0, ph, flt, rs, ws);
    chk("R7 user read ok", {31'h0, flt}, 32'h0);
    chk("R7 user read phys", ph, 32'h66666060);
    xlate(h, 1, 0, 0, ph, flt, rs, ws);
    chk("R7 sup write ok", {31'h0, flt}, 32'h0);
    chk("R7 sup write phys", ph, 32'h66666060);
  endtask

  task automatic t_flush();
    xlate(32'h0040_3000, 0, 0, 0, ph, flt, rs, ws);
    chk("R12 cached before", rs, 0);
    do_flush();
    xlate(32'h0040_3000, 0, 0, 0, ph, flt, rs, ws);
    chk("R12 flush rewalk", rs, 2);
    set_base(BASE);
    xlate(32'h0040_3000, 0, 0, 0, ph, flt, rs, ws);
    chk("R12 base write rewalk", rs, 2);
    chk("R12 phys", ph, 32'hABCDE000);
  endtask

  task automatic t_rr();
    logic [31:0] p;
    do_flush();
    for (int i = 0; i < 33; i++) begin
      p = 32'h0400_0000 + (i << 12);
      map_page(p, FP|FW|FU|FA, FP|FW|FU|FA, 20'h70000 + 20'(i));
      xlate(p, 0, 0, 0, ph, flt, rs, ws);
    end
    xlate(32'h0400_0000, 0, 0, 0, ph, flt, rs, ws);
    chk("R11 first evicted", rs, 2);
    chk("R11 refill phys", ph, 32'h70000000);
    xlate(32'h0400_2000, 0, 0, 0, ph, flt, rs, ws);
    chk("R11 third kept", rs, 0);
    chk("R11 third phys", ph, 32'h70002000);
    xlate(32'h0400_1000, 0, 0, 0, ph, flt, rs, ws);
    chk("R11 second evicted", rs, 2);
  endtask

  task automatic t_back();
    xlate(32'h0040_3444, 0, 0, 5, ph, flt, rs, ws);
    chk("R13 phys after hold", ph, 32'hABCDE444);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog act=%0d exp=done", cyc);
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_walk();
    t_dirty();
    t_dir_dirty();
    t_absent();
    t_user();
    t_rw();
    t_flush();
    t_rr();
    t_back();
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule